// File: doc/BRIEF.md
# Packet Page Allocator

This block manages the packet memory of a network controller. The memory is a fixed pool of numbered pages. The block tracks which pages are free and keeps two ordered queues of page numbers: one holds received packets that wait for the host, and one holds packets that the host has queued for transmission. The packet data and the MAC datapath sit outside this block. Only page numbers pass through it.

The host writes a command byte, and the operation code sits in the top three bits of that byte. The block raises `busy` for a fixed number of cycles and then applies the effect. The host polls `busy` until it clears, then reads the allocation result or the receive status word. The receive side of the MAC claims a page with a single pulse. The transmit side signals that the head packet has left with a single pulse, which returns that page to the pool. `alloc_done` and `rx_pending` feed an interrupt status register.

Top module: `pkt_page_mgr`

## Requirements
- R1: On `cmd_wr`, bits 7:5 of `cmd_byte` select the operation: 0 none, 1 allocate, 2 pool reset, 3 drop the receive head, 4 drop and free the receive head, 5 free the page held in the packet-number register, 6 queue the packet-number register for transmit, 7 empty the transmit queue. Bits 4:0 have no effect.
- R2: For an isolated command, `busy` is high for exactly CMD_LAT cycles starting the cycle after the write. The command's effect is visible in the cycle where `busy` falls.
- R3: Allocate claims the lowest-numbered free page and sets `alloc_result` to that page number with bit 7 clear. It also pulses `alloc_done` high for one cycle.
- R4: Allocate with no free page sets `alloc_result` to 0x80, does not pulse `alloc_done`, and leaves the pool unchanged. After reset, `alloc_result` is 0x80.
- R5: Pool reset frees every page and empties both queues. It leaves `alloc_result` unchanged.
- R6: `rx_status` bit 15 is set when the receive queue is empty. The low bits hold the head page number, or 0 when the queue is empty. `rx_pending` is high exactly when the queue is non-empty.
- R7: An `rx_push` pulse claims the lowest free page and appends it to the receive queue. The pulse is ignored while `busy` is high, when no page is free, or when the receive queue is full.
- R8: Operation 3 removes the receive head and leaves its page allocated. Operation 4 removes the head and frees its page. Both are ignored when the receive queue is empty.
- R9: Operation 5 frees the page last written through `pnum_wr`. Freeing a page that is already free changes nothing.
- R10: Operation 6 appends the packet-number register to the transmit queue, unless the queue is full. `tx_head_valid`/`tx_head_page` show the queue head. A `tx_done` pulse while `busy` is low removes the head and frees its page.
- R11: Operation 7 empties the transmit queue and leaves the pages of the removed packets allocated.
- R12: A command written while `busy` is high is held in one slot. It starts as soon as the current command completes, and `busy` stays high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte, operation in bits 7:5 |
| pnum_wr | input | 1 | Packet-number register write strobe |
| pnum_in | input | clog2(NUM_PAGES) | Page number for free and transmit-queue operations |
| rx_push | input | 1 | Receive path claims a page for a new packet |
| tx_done | input | 1 | Transmit path finished the head packet |
| busy | output | 1 | A command is executing or held |
| alloc_result | output | 8 | Last allocation: page number, bit 7 = failed |
| alloc_done | output | 1 | One-cycle pulse on successful allocation |
| rx_status | output | 16 | Bit 15 = receive queue empty, low bits = head page |
| rx_pending | output | 1 | Receive queue holds at least one packet |
| tx_head_valid | output | 1 | Transmit queue is non-empty |
| tx_head_page | output | clog2(NUM_PAGES) | Page at the transmit queue head |

## Verification
A corrupted free bitmap is visible at the ports through the next allocate or `rx_push`. Either returns the wrong page number, or it reports a failure or success that disagrees with a bench model of the pool, and this shows one command latency later. Queue pointer or count errors are visible right after the operation that causes them, through the wrong head page, a wrong empty flag in `rx_status` bit 15, or a wrong `tx_head_valid`. A timing fault in the command sequencer is caught within CMD_LAT cycles by a `busy` value sampled every cycle of the window. The bench mixes fixed-seed random operations with directed exhaustion, double-free and held-command cases, and compares every output against that model after each operation.

// File: rtl/pkt_mgr_pkg.sv
package pkt_mgr_pkg;

   typedef enum logic [2:0] {
      OP_NOP      = 3'd0,
      OP_ALLOC    = 3'd1,
      OP_RESET    = 3'd2,
      OP_RX_DROP  = 3'd3,
      OP_RX_FREE  = 3'd4,
      OP_FREE_PKT = 3'd5,
      OP_TX_QUEUE = 3'd6,
      OP_TX_FLUSH = 3'd7
   } mmu_op_e;

   localparam int unsigned OP_MSB     = 7;
   localparam int unsigned OP_LSB     = 5;
   localparam int unsigned FAIL_BIT   = 7;
   localparam int unsigned RX_EMPTY_B = 15;

endpackage

// File: rtl/pkt_cmd_seq.sv
module pkt_cmd_seq
   import pkt_mgr_pkg::*;
#(
   parameter int unsigned CMD_LAT = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr,
   input  mmu_op_e op_in,
   output logic    busy,
   output logic    fire,
   output mmu_op_e fire_op
);

   localparam int unsigned CW = (CMD_LAT > 1) ? $clog2(CMD_LAT) : 1;

   generate
      if (CMD_LAT < 1) begin : g_bad_lat
         $error("CMD_LAT must be at least 1");
      end
   endgenerate

   logic          act_q, pend_q;
   mmu_op_e       cur_q, pend_op_q;
   logic [CW-1:0] cnt_q;

   assign busy    = act_q;
   assign fire    = act_q && (cnt_q == '0);
   assign fire_op = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         pend_q    <= 1'b0;
         cur_q     <= OP_NOP;
         pend_op_q <= OP_NOP;
         cnt_q     <= '0;
      end else if (fire) begin
         if (pend_q) begin
            cur_q <= pend_op_q;
            cnt_q <= CW'(CMD_LAT - 1);
            if (wr) pend_op_q <= op_in;
            else    pend_q    <= 1'b0;
         end else if (wr) begin
            cur_q <= op_in;
            cnt_q <= CW'(CMD_LAT - 1);
         end else begin
            act_q <= 1'b0;
         end
      end else if (act_q) begin
         cnt_q <= cnt_q - 1'b1;
         if (wr && !pend_q) begin
            pend_q    <= 1'b1;
            pend_op_q <= op_in;
         end
      end else if (wr) begin
         act_q <= 1'b1;
         cur_q <= op_in;
         cnt_q <= CW'(CMD_LAT - 1);
      end
   end

   // R2: a write to an idle sequencer raises busy on the next cycle
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !act_q) |=> busy);

   // R12: a held command keeps busy high past the current completion
   a_r12_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pend_q) |=> busy);

endmodule

// File: rtl/pkt_page_pool.sv
module pkt_page_pool #(
   parameter int unsigned NUM_PAGES = 8,
   parameter int unsigned PW        = $clog2(NUM_PAGES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_all,
   input  logic          claim,
   input  logic          rel_en,
   input  logic [PW-1:0] rel_page,
   output logic          any_free,
   output logic [PW-1:0] low_page
);

   logic [NUM_PAGES-1:0] free_q;
   logic [NUM_PAGES:0]   below;
   logic [NUM_PAGES-1:0] pick;
   logic                 rel_ok;

   assign below[0] = 1'b0;
   genvar gi;
   generate
      for (gi = 0; gi < NUM_PAGES; gi++) begin : g_prio
         assign below[gi+1] = below[gi] | free_q[gi];
         assign pick[gi]    = free_q[gi] & ~below[gi];
      end
      if (NUM_PAGES == (1 << PW)) begin : g_full_range
         assign rel_ok = 1'b1;
      end else begin : g_part_range
         assign rel_ok = (32'(rel_page) < NUM_PAGES);
      end
   endgenerate

   assign any_free = below[NUM_PAGES];

   always_comb begin
      low_page = '0;
      for (int i = 0; i < NUM_PAGES; i++)
         if (pick[i]) low_page = low_page | PW'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q <= '1;
      end else if (clear_all) begin
         free_q <= '1;
      end else begin
         if (claim && any_free)  free_q[low_page] <= 1'b0;
         if (rel_en && rel_ok)   free_q[rel_page] <= 1'b1;
      end
   end

   // R3: a claimed page is no longer free
   a_r3_claim_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && any_free && !clear_all && !rel_en) |=> !free_q[$past(low_page)]);

   // R9: a released page is free afterwards
   a_r9_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en && rel_ok && !clear_all) |=> free_q[$past(rel_page)]);

   // R5: pool reset leaves every page free
   a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> (&free_q));

endmodule

// File: rtl/pkt_page_fifo.sv
module pkt_page_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [PW-1:0] din,
   input  logic          pop,
   output logic [PW-1:0] head,
   output logic          empty,
   output logic          full
);

   localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("queue DEPTH must be at least 2");
      end
   endgenerate

   logic [PW-1:0]  mem [DEPTH];
   logic [AW-1:0]  rd_q, wr_q;
   logic [CNW-1:0] cnt_q;
   logic           do_push, do_pop;

   function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNW'(DEPTH));
   assign head    = mem[rd_q];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= ptr_inc(wr_q);
         if (do_pop)  rd_q <= ptr_inc(rd_q);
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   // R7 / R10: a push into a full queue leaves its occupancy unchanged
   a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full);

   // R8: a pop from an empty queue leaves it empty
   a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
   import pkt_mgr_pkg::*;
#(
   parameter int unsigned NUM_PAGES = 8,
   parameter int unsigned CMD_LAT   = 2,
   parameter int unsigned RXQ_DEPTH = NUM_PAGES,
   parameter int unsigned TXQ_DEPTH = NUM_PAGES
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_wr,
   input  logic [7:0]                   cmd_byte,
   input  logic                         pnum_wr,
   input  logic [$clog2(NUM_PAGES)-1:0] pnum_in,
   input  logic                         rx_push,
   input  logic                         tx_done,
   output logic                         busy,
   output logic [7:0]                   alloc_result,
   output logic                         alloc_done,
   output logic [15:0]                  rx_status,
   output logic                         rx_pending,
   output logic                         tx_head_valid,
   output logic [$clog2(NUM_PAGES)-1:0] tx_head_page
);

   localparam int unsigned PW = $clog2(NUM_PAGES);

   generate
      if (NUM_PAGES < 2 || NUM_PAGES > 128) begin : g_bad_pages
         $error("NUM_PAGES must lie in 2..128");
      end
   endgenerate

   wire cmd_unused = ^cmd_byte[OP_LSB-1:0];

   logic          fire;
   mmu_op_e       fire_op;
   logic [PW-1:0] pnum_q;
   logic          any_free;
   logic [PW-1:0] low_page;
   logic          rx_take, tx_take, claim, rel_en, clear_all;
   logic [PW-1:0] rel_page;
   logic [PW-1:0] rx_head, tx_head;
   logic          rxq_empty, rxq_full, txq_empty, txq_full;
   logic          rxq_pop, txq_push, txq_flush;

   pkt_cmd_seq #(.CMD_LAT(CMD_LAT)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cmd_wr),
      .op_in   (mmu_op_e'(cmd_byte[OP_MSB:OP_LSB])),
      .busy    (busy),
      .fire    (fire),
      .fire_op (fire_op)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pnum_q <= '0;
      else if (pnum_wr) pnum_q <= pnum_in;
   end

   assign rx_take   = rx_push && !busy && any_free && !rxq_full;
   assign tx_take   = tx_done && !busy && !txq_empty;
   assign claim     = rx_take || (fire && fire_op == OP_ALLOC);
   assign clear_all = fire && (fire_op == OP_RESET);
   assign rxq_pop   = fire && (fire_op == OP_RX_DROP || fire_op == OP_RX_FREE);
   assign txq_push  = fire && (fire_op == OP_TX_QUEUE);
   assign txq_flush = clear_all || (fire && fire_op == OP_TX_FLUSH);
   assign rel_en    = tx_take
                   || (fire && fire_op == OP_RX_FREE && !rxq_empty)
                   || (fire && fire_op == OP_FREE_PKT);
   assign rel_page  = tx_take                   ? tx_head :
                      (fire_op == OP_RX_FREE)   ? rx_head : pnum_q;

   pkt_page_pool #(.NUM_PAGES(NUM_PAGES), .PW(PW)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (clear_all),
      .claim     (claim),
      .rel_en    (rel_en),
      .rel_page  (rel_page),
      .any_free  (any_free),
      .low_page  (low_page)
   );

   pkt_page_fifo #(.DEPTH(RXQ_DEPTH), .PW(PW)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (clear_all),
      .push  (rx_take),
      .din   (low_page),
      .pop   (rxq_pop),
      .head  (rx_head),
      .empty (rxq_empty),
      .full  (rxq_full)
   );

   pkt_page_fifo #(.DEPTH(TXQ_DEPTH), .PW(PW)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (txq_flush),
      .push  (txq_push),
      .din   (pnum_q),
      .pop   (tx_take),
      .head  (tx_head),
      .empty (txq_empty),
      .full  (txq_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_result <= 8'h80;
         alloc_done   <= 1'b0;
      end else begin
         alloc_done <= 1'b0;
         if (fire && fire_op == OP_ALLOC) begin
            if (any_free) begin
               alloc_result <= 8'(low_page);
               alloc_done   <= 1'b1;
            end else begin
               alloc_result <= 8'h80;
            end
         end
      end
   end

   assign rx_status     = {rxq_empty, 15'd0} | (rxq_empty ? 16'd0 : 16'(rx_head));
   assign rx_pending    = !rxq_empty;
   assign tx_head_valid = !txq_empty;
   assign tx_head_page  = txq_empty ? '0 : tx_head;

   // R4: a completion pulse never comes with a failed result
   a_r4_done_ok: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_done |-> !alloc_result[FAIL_BIT]);

   // R11: emptying the transmit queue clears its head flag
   a_r11_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && fire_op == OP_TX_FLUSH) |=> !tx_head_valid);

   // R7: receive path is locked out while a command runs
   a_r7_busy_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rx_push && !fire) |=> $stable(rx_pending) || !rx_pending);

   // R5: pool reset empties the receive queue
   a_r5_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> rx_status[RX_EMPTY_B]);

endmodule

// File: tb/pkt_page_mgr_tb_top.sv
module pkt_page_mgr_tb_top;

   localparam int NP  = 8;
   localparam int LAT = 2;
   localparam int RXD = NP;
   localparam int TXD = NP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_byte = 8'd0;
   logic       pnum_wr = 1'b0;
   logic [2:0] pnum_in = 3'd0;
   logic       rx_push = 1'b0;
   logic       tx_done = 1'b0;
   logic       busy, alloc_done, rx_pending, tx_head_valid;
   logic [7:0] alloc_result;
   logic [15:0] rx_status;
   logic [2:0] tx_head_page;

   always #5 clk = ~clk;

   pkt_page_mgr #(.NUM_PAGES(NP), .CMD_LAT(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
      .pnum_wr(pnum_wr), .pnum_in(pnum_in), .rx_push(rx_push), .tx_done(tx_done),
      .busy(busy), .alloc_result(alloc_result), .alloc_done(alloc_done),
      .rx_status(rx_status), .rx_pending(rx_pending),
      .tx_head_valid(tx_head_valid), .tx_head_page(tx_head_page)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   bit m_free [NP];
   int m_rxq [$];
   int m_txq [$];
   int m_res = 8'h80;
   int m_pnum = 0;
   int m_done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int m_lowest();
      for (int i = 0; i < NP; i++) if (m_free[i]) return i;
      return -1;
   endfunction

   function automatic int exp_rx_status();
      return (m_rxq.size() == 0) ? 16'h8000 : m_rxq[0];
   endfunction

   function automatic void m_apply(input int op);
      int p;
      m_done = 0;
      case (op)
         1: begin
            p = m_lowest();
            if (p >= 0) begin m_free[p] = 0; m_res = p; m_done = 1; end
            else m_res = 8'h80;
         end
         2: begin
            for (int i = 0; i < NP; i++) m_free[i] = 1;
            m_rxq.delete(); m_txq.delete();
         end
         3: if (m_rxq.size() > 0) void'(m_rxq.pop_front());
         4: if (m_rxq.size() > 0) begin p = m_rxq.pop_front(); m_free[p] = 1; end
         5: m_free[m_pnum] = 1;
         6: if (m_txq.size() < TXD) m_txq.push_back(m_pnum);
         7: m_txq.delete();
         default: ;
      endcase
   endfunction

   task automatic cmp_outs(input string tag);
      chk({tag, " R4 R3 result"}, alloc_result, m_res);
      chk({tag, " R6 rx_status"}, rx_status, exp_rx_status());
      chk({tag, " R6 rx_pending"}, rx_pending, m_rxq.size() > 0);
      chk({tag, " R10 tx_valid"}, tx_head_valid, m_txq.size() > 0);
      chk({tag, " R10 tx_page"}, tx_head_page, (m_txq.size() > 0) ? m_txq[0] : 0);
   endtask

   task automatic run_cmd(input int op, input int low5, input string tag);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_byte = {3'(op), 5'(low5)};
      @(negedge clk);
      cmd_wr = 1'b0;
      chk({tag, " R2 busy rise"}, busy, 1);
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         chk({tag, " R2 busy hold"}, busy, 1);
      end
      @(negedge clk);
      m_apply(op);
      chk({tag, " R2 busy fall"}, busy, 0);
      chk({tag, " R3 alloc_done"}, alloc_done, m_done);
      cmp_outs(tag);
   endtask

   task automatic set_pnum(input int v);
      @(negedge clk);
      pnum_wr = 1'b1; pnum_in = 3'(v);
      @(negedge clk);
      pnum_wr = 1'b0;
      m_pnum = v;
   endtask

   task automatic do_rx_push(input string tag);
      int p;
      @(negedge clk);
      rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
      p = m_lowest();
      if (p >= 0 && m_rxq.size() < RXD) begin m_free[p] = 0; m_rxq.push_back(p); end
      cmp_outs({tag, " R7"});
   endtask

   task automatic do_tx_done(input string tag);
      int p;
      @(negedge clk);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      if (m_txq.size() > 0) begin p = m_txq.pop_front(); m_free[p] = 1; end
      cmp_outs({tag, " R10"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NP; i++) m_free[i] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R4, R6, R2)
      chk("reset R2 busy", busy, 0);
      chk("reset R3 alloc_done", alloc_done, 0);
      cmp_outs("reset");

      // R3: three allocations give 0,1,2
      run_cmd(1, 0, "alloc0");
      run_cmd(1, 0, "alloc1");
      run_cmd(1, 5'h1f, "alloc2 R1 low bits");
      chk("R3 third page", alloc_result, 2);

      // R9: free page 1, then reuse it; double free is ignored
      set_pnum(1);
      run_cmd(5, 0, "free1 R9");
      run_cmd(5, 0, "free1 again R9");
      run_cmd(1, 0, "realloc R9");
      chk("R9 reuse page 1", alloc_result, 1);
      set_pnum(5);
      run_cmd(5, 0, "free unused R9");
      run_cmd(1, 0, "alloc after dbl R9");
      chk("R9 pool unchanged", alloc_result, 3);

      // R7, R6, R8: receive queue
      do_rx_push("rx a");
      do_rx_push("rx b");
      chk("R6 head page", rx_status, 4);
      run_cmd(3, 0, "rx drop R8");
      run_cmd(4, 0, "rx free R8");
      chk("R8 empty", rx_status, 16'h8000);
      run_cmd(1, 0, "alloc after rx R8");
      chk("R8 page 5 freed, 4 kept", alloc_result, 5);
      run_cmd(4, 0, "rx free empty R8");

      // R7: rx_push while busy is ignored, also tx_done
      set_pnum(0);
      run_cmd(6, 0, "txq R10");
      @(negedge clk);
      cmd_wr = 1'b1; cmd_byte = 8'h00;
      @(negedge clk);
      cmd_wr = 1'b0; rx_push = 1'b1; tx_done = 1'b1;
      @(negedge clk);
      rx_push = 1'b0; tx_done = 1'b0;
      for (int k = 1; k < LAT; k++) @(negedge clk);
      chk("R7 busy lock busy", busy, 0);
      cmp_outs("busy lock R7");

      // R10: transmit complete frees page 0
      do_tx_done("txdone");
      run_cmd(1, 0, "alloc after tx R10");
      chk("R10 page 0 freed", alloc_result, 0);

      // R11: flush keeps pages allocated
      set_pnum(3);
      run_cmd(6, 0, "txq b R11");
      run_cmd(7, 0, "flush R11");
      chk("R11 empty", tx_head_valid, 0);
      run_cmd(1, 0, "alloc after flush R11");
      chk("R11 page 3 held", alloc_result, 6);

      // R4: exhaust the pool
      run_cmd(1, 0, "alloc last R4");
      run_cmd(1, 0, "alloc fail R4");
      chk("R4 fail code", alloc_result, 8'h80);
      do_rx_push("rx none free R7");

      // R12: held command
      @(negedge clk);
      cmd_wr = 1'b1; cmd_byte = 8'h40;
      @(negedge clk);
      cmd_byte = 8'h20;
      @(negedge clk);
      cmd_wr = 1'b0;
      for (int k = 2; k < LAT; k++) @(negedge clk);
      @(negedge clk);
      m_apply(2);
      chk("R12 busy continues", busy, 1);
      cmp_outs("held first R5");
      for (int k = 1; k < LAT; k++) @(negedge clk);
      @(negedge clk);
      m_apply(1);
      chk("R12 busy ends", busy, 0);
      chk("R12 held alloc", alloc_result, 0);
      chk("R12 alloc_done", alloc_done, 1);
      cmp_outs("held second R12");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel < 5) begin
            run_cmd(int'($urandom_range(0, 7) == 2 ? $urandom_range(0, 7) : $urandom_range(0, 7)),
                    int'($urandom_range(0, 31)), "rand cmd R1");
         end else if (sel < 6) set_pnum(int'($urandom_range(0, NP - 1)));
         else if (sel < 8) do_rx_push("rand rx");
         else do_tx_done("rand tx");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule